// File: doc/BRIEF.md
# SuperSpeed PHY Power Sequencer

This block takes a SuperSpeed PHY from reset to a tuned, running state, and later parks it in a low-power retention state. It owns two 32-bit registers that feed the PHY: a control word and a parameter word. It reaches the PHY's internal lane registers through a small request/acknowledge control port. A read on that port is always issued twice, because the first result after a write may be stale.

A one-cycle start command runs the bring-up. The PHY is pulsed into reset, its reference source is picked from the external-oscillator flag, and it is given time to settle before it is enabled. The block then read-modify-writes the lane-0 receive and transmit override registers and merges fixed tuning fields into the parameter word, checking that word through a readback path. A one-cycle stop command runs the three-step retention entry. Each sequence ends with a one-cycle done pulse, and an error flag beside it reports an abandoned or mismatched run.

Top module: `sspwr_seq`

## Requirements
- R1: While reset is held, the control word equals CTRL_INIT, the parameter word equals PARAM_INIT, and done, error and the port request are all low.
- R2: Start from idle sets control bit 7 and leaves the other bits unchanged. Bit 7 stays set for exactly RST_MS*CLK_KHZ cycles, after which the whole control word returns to its value from before the start.
- R3: One cycle after that restore, control bit 28 takes the value of the external-oscillator flag. Exactly SETTLE_MS*CLK_KHZ cycles after that, control bits 8 (enable) and 24 (lane power) are set.
- R4: A port transaction holds request, write flag, address and write data steady until acknowledge. Every read is performed twice, and only the second result is used. A bring-up makes exactly four reads and two writes.
- R5: The lane-0 receive override register at address 0x1006 is written back with bit 6 cleared, bit 7 set, bits 10:8 equal to 3 and bit 11 set, and all other bits kept from the read. It is written before the transmit register.
- R6: The lane-0 transmit override register at address 0x1002 is written back with bits 6:0 equal to 127, bits 13:7 equal to 22 and bit 14 set, and bit 15 kept from the read.
- R7: The parameter word gets bits 26:20 set to 127, bits 13:8 set to 22 and bits 2:0 set to 5, and all its other bits are kept.
- R8: One cycle after the parameter write, the readback input is masked with 0x07F03F07 and compared with 0x07F01605. If they differ, error is raised in the same cycle as done. Error is never high without done.
- R9: If an acknowledge does not come within ACK_LIMIT cycles, the bring-up stops at once. No further port transaction happens, the parameter word is left unchanged, and done and error pulse together.
- R10: Stop from idle clears control bit 8, then one cycle later clears bit 28, then one cycle later sets bit 27. Done pulses in the same cycle that bit 27 is written.
- R11: Start and stop are ignored while a sequence runs. Start wins when both arrive in idle. Done lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Bring-up command pulse |
| stop_i | input | 1 | Retention-entry command pulse |
| ext_ref_i | input | 1 | External reference oscillator present |
| phy_ctrl_o | output | 32 | PHY control word |
| param_o | output | 32 | PHY parameter word |
| param_rb_i | input | 32 | Readback of the parameter word |
| cr_req_o | output | 1 | Control-port request |
| cr_wr_o | output | 1 | Control-port write (1) or read (0) |
| cr_addr_o | output | CR_AW | Control-port register address |
| cr_wdata_o | output | 16 | Control-port write data |
| cr_ack_i | input | 1 | Control-port acknowledge, one cycle |
| cr_rdata_i | input | 16 | Control-port read data, valid with acknowledge |
| done_o | output | 1 | Sequence finished, one-cycle pulse |
| err_o | output | 1 | Abort or readback mismatch, only with done |

## Verification
The bench builds the block with CLK_KHZ=10, which gives a 20-cycle reset hold and a 300-cycle settle window. Every timing edge of a bring-up can therefore be measured cycle by cycle. ACK_LIMIT=16 is set against a modelled port latency of three cycles, so a silent port triggers the abort path quickly. A non-zero PARAM_INIT lets the merge show that bits outside the mask are kept. The port model returns junk on the first read after each write, so only a design that uses the second read writes the expected values.

// File: rtl/sspwr_pkg.sv
`timescale 1ns/1ps
package sspwr_pkg;
  localparam int CR_DW = 16;

  // control word bit positions (decoded by the PHY)
  localparam int CTL_RST      = 7;
  localparam int CTL_EN       = 8;
  localparam int CTL_LANE_PWR = 24;
  localparam int CTL_PD       = 27;
  localparam int CTL_REFPAD   = 28;

  localparam logic [15:0] RX_OVR_ADDR = 16'h1006;
  localparam logic [15:0] TX_OVR_ADDR = 16'h1002;

  localparam logic [31:0] PRM_MASK = 32'h07F0_3F07;
  localparam logic [31:0] PRM_VAL  = 32'h07F0_1605;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_ON, S_RST_WAIT, S_REF, S_REF_WAIT,
    S_RX_RD, S_RX_WR, S_TX_RD, S_TX_WR, S_PARAM, S_CHECK,
    S_DN_EN, S_DN_PAD, S_DN_PD
  } seq_st_e;

  // receive override: eq enable off, its override on, eq = 3, eq override on
  function automatic logic [CR_DW-1:0] rx_tune(input logic [CR_DW-1:0] d);
    logic [CR_DW-1:0] r;
    r = d & ~16'h0FC0;
    r = r | 16'h0080 | (16'd3 << 8) | 16'h0800;
    return r;
  endfunction

  // transmit override: amplitude 127, pre-emphasis 22, enable
  function automatic logic [CR_DW-1:0] tx_tune(input logic [CR_DW-1:0] d);
    logic [CR_DW-1:0] r;
    r = d & ~16'h7FFF;
    r = r | 16'h4000 | (16'd22 << 7) | 16'd127;
    return r;
  endfunction

  function automatic logic [31:0] param_merge(input logic [31:0] old);
    return (old & ~PRM_MASK) | PRM_VAL;
  endfunction
endpackage

// File: rtl/sspwr_delay.sv
`timescale 1ns/1ps
module sspwr_delay #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          fire_o
);
  logic [CW-1:0] cnt;
  logic          run;

  assign fire_o = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start_i) begin
      cnt <= len_i - 1'b1;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o && !start_i |=> !fire_o); // R3
endmodule

// File: rtl/sspwr_cr_port.sv
`timescale 1ns/1ps
module sspwr_cr_port #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int ACK_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [DW-1:0] rdata_o,
  output logic          cr_req_o,
  output logic          cr_wr_o,
  output logic [AW-1:0] cr_addr_o,
  output logic [DW-1:0] cr_wdata_o,
  input  logic          cr_ack_i,
  input  logic [DW-1:0] cr_rdata_i
);
  localparam int TW = $clog2(ACK_LIMIT + 1);

  logic          dummy;   // a discarded first read is outstanding
  logic          rearm;   // one idle cycle between the two reads
  logic [TW-1:0] wcnt;
  logic          timeout_hit;

  assign timeout_hit = cr_req_o && !cr_ack_i && (wcnt == TW'(ACK_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_req_o   <= 1'b0;
      cr_wr_o    <= 1'b0;
      cr_addr_o  <= '0;
      cr_wdata_o <= '0;
      rdata_o    <= '0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
      dummy      <= 1'b0;
      rearm      <= 1'b0;
      wcnt       <= '0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      if (go_i && !cr_req_o && !rearm) begin
        cr_req_o   <= 1'b1;
        cr_wr_o    <= wr_i;
        cr_addr_o  <= addr_i;
        cr_wdata_o <= wdata_i;
        dummy      <= !wr_i;
        wcnt       <= '0;
      end else if (rearm) begin
        rearm    <= 1'b0;
        cr_req_o <= 1'b1;
        wcnt     <= '0;
      end else if (cr_req_o) begin
        if (cr_ack_i) begin
          cr_req_o <= 1'b0;
          if (dummy) begin
            dummy <= 1'b0;
            rearm <= 1'b1;
          end else begin
            done_o  <= 1'b1;
            rdata_o <= cr_rdata_i;
          end
        end else if (timeout_hit) begin
          cr_req_o <= 1'b0;
          dummy    <= 1'b0;
          fail_o   <= 1'b1;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cr_req_o && !cr_ack_i && !timeout_hit |=>
      cr_req_o && $stable(cr_addr_o) && $stable(cr_wr_o) && $stable(cr_wdata_o)); // R4
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o)); // R9
endmodule

// File: rtl/sspwr_seq.sv
`timescale 1ns/1ps
module sspwr_seq
  import sspwr_pkg::*;
#(
  parameter int          CLK_KHZ    = 19200,
  parameter int          RST_MS     = 2,
  parameter int          SETTLE_MS  = 30,
  parameter int          ACK_LIMIT  = 64,
  parameter int          CR_AW      = 16,
  parameter logic [31:0] CTRL_INIT  = 32'h0,
  parameter logic [31:0] PARAM_INIT = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ext_ref_i,
  output logic [31:0]      phy_ctrl_o,
  output logic [31:0]      param_o,
  input  logic [31:0]      param_rb_i,
  output logic             cr_req_o,
  output logic             cr_wr_o,
  output logic [CR_AW-1:0] cr_addr_o,
  output logic [15:0]      cr_wdata_o,
  input  logic             cr_ack_i,
  input  logic [15:0]      cr_rdata_i,
  output logic             done_o,
  output logic             err_o
);
  localparam int RST_CYC = RST_MS * CLK_KHZ;
  localparam int SET_CYC = SETTLE_MS * CLK_KHZ;
  localparam int MAX_CYC = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  seq_st_e         st;
  logic [31:0]     ctrl_save;
  logic [CR_DW-1:0] rd_buf;
  logic            launched;

  // named internal events
  logic             dly_start, dly_fire;
  logic [CW-1:0]    dly_len;
  logic             cr_state, cr_go, cr_wr, cr_done, cr_fail;
  logic [CR_AW-1:0] cr_addr;
  logic [CR_DW-1:0] cr_wdata, cr_rd;
  logic             rb_mismatch;

  assign dly_start = (st == S_RST_ON) || (st == S_REF);
  assign dly_len   = (st == S_REF) ? CW'(SET_CYC) : CW'(RST_CYC);

  assign cr_state = (st == S_RX_RD) || (st == S_RX_WR) || (st == S_TX_RD) || (st == S_TX_WR);
  assign cr_go    = cr_state && !launched;
  assign cr_wr    = (st == S_RX_WR) || (st == S_TX_WR);
  assign cr_addr  = ((st == S_RX_RD) || (st == S_RX_WR)) ? CR_AW'(RX_OVR_ADDR) : CR_AW'(TX_OVR_ADDR);
  assign cr_wdata = (st == S_RX_WR) ? rx_tune(rd_buf) : tx_tune(rd_buf);

  assign rb_mismatch = (param_rb_i & PRM_MASK) != PRM_VAL;

  sspwr_delay #(.CW(CW)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (dly_start),
    .len_i   (dly_len),
    .fire_o  (dly_fire)
  );

  sspwr_cr_port #(.AW(CR_AW), .DW(CR_DW), .ACK_LIMIT(ACK_LIMIT)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (cr_go),
    .wr_i       (cr_wr),
    .addr_i     (cr_addr),
    .wdata_i    (cr_wdata),
    .done_o     (cr_done),
    .fail_o     (cr_fail),
    .rdata_o    (cr_rd),
    .cr_req_o   (cr_req_o),
    .cr_wr_o    (cr_wr_o),
    .cr_addr_o  (cr_addr_o),
    .cr_wdata_o (cr_wdata_o),
    .cr_ack_i   (cr_ack_i),
    .cr_rdata_i (cr_rdata_i)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      phy_ctrl_o <= CTRL_INIT;
      param_o    <= PARAM_INIT;
      ctrl_save  <= '0;
      rd_buf     <= '0;
      launched   <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (cr_go) launched <= 1'b1;
      unique case (st)
        S_IDLE: begin
          if (start_i)     st <= S_RST_ON;
          else if (stop_i) st <= S_DN_EN;
        end
        S_RST_ON: begin
          ctrl_save           <= phy_ctrl_o;
          phy_ctrl_o[CTL_RST] <= 1'b1;
          st                  <= S_RST_WAIT;
        end
        S_RST_WAIT: if (dly_fire) begin
          phy_ctrl_o <= ctrl_save;
          st         <= S_REF;
        end
        S_REF: begin
          phy_ctrl_o[CTL_REFPAD] <= ext_ref_i;
          st                     <= S_REF_WAIT;
        end
        S_REF_WAIT: if (dly_fire) begin
          phy_ctrl_o[CTL_EN]       <= 1'b1;
          phy_ctrl_o[CTL_LANE_PWR] <= 1'b1;
          st                       <= S_RX_RD;
        end
        S_RX_RD, S_RX_WR, S_TX_RD, S_TX_WR: begin
          if (cr_fail) begin
            launched <= 1'b0;
            done_o   <= 1'b1;
            err_o    <= 1'b1;
            st       <= S_IDLE;
          end else if (cr_done) begin
            launched <= 1'b0;
            if (!cr_wr) rd_buf <= cr_rd;
            case (st)
              S_RX_RD: st <= S_RX_WR;
              S_RX_WR: st <= S_TX_RD;
              S_TX_RD: st <= S_TX_WR;
              default: st <= S_PARAM;
            endcase
          end
        end
        S_PARAM: begin
          param_o <= param_merge(param_o);
          st      <= S_CHECK;
        end
        S_CHECK: begin
          done_o <= 1'b1;
          err_o  <= rb_mismatch;
          st     <= S_IDLE;
        end
        S_DN_EN: begin
          phy_ctrl_o[CTL_EN] <= 1'b0;
          st                 <= S_DN_PAD;
        end
        S_DN_PAD: begin
          phy_ctrl_o[CTL_REFPAD] <= 1'b0;
          st                     <= S_DN_PD;
        end
        default: begin
          phy_ctrl_o[CTL_PD] <= 1'b1;
          done_o             <= 1'b1;
          st                 <= S_IDLE;
        end
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o); // R8
  AST_RST_RELEASE_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_ctrl_o[CTL_RST]) |-> $past(dly_fire)); // R2
  AST_ENABLE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_ctrl_o[CTL_EN]) |-> $past(dly_fire)); // R3
  AST_ABORT_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    cr_fail |=> done_o && err_o); // R9
  AST_PARAM_MASKED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(param_o & ~PRM_MASK)); // R7
endmodule

// File: tb/sspwr_seq_tb_top.sv
`timescale 1ns/1ps
module sspwr_seq_tb_top;
  localparam int CLK_KHZ   = 10;
  localparam int RST_MS    = 2;
  localparam int SETTLE_MS = 30;
  localparam int ACK_LIMIT = 16;
  localparam int LAT       = 3;
  localparam int N1        = RST_MS * CLK_KHZ;
  localparam int N2        = SETTLE_MS * CLK_KHZ;
  localparam logic [31:0] PINIT = 32'hF80F_C0F8;

  logic        clk = 1'b0;
  logic        rst_n, start, stop, ext_ref;
  logic [31:0] phy_ctrl, param, param_rb, rb_flip;
  logic        cr_req, cr_wr, cr_ack, done, err;
  logic [15:0] cr_addr, cr_wdata, cr_rdata;

  always #2.5 clk = ~clk;

  assign param_rb = param ^ rb_flip;

  sspwr_seq #(.CLK_KHZ(CLK_KHZ), .RST_MS(RST_MS), .SETTLE_MS(SETTLE_MS),
              .ACK_LIMIT(ACK_LIMIT), .CR_AW(16), .CTRL_INIT(32'h0),
              .PARAM_INIT(PINIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .ext_ref_i(ext_ref),
    .phy_ctrl_o(phy_ctrl), .param_o(param), .param_rb_i(param_rb),
    .cr_req_o(cr_req), .cr_wr_o(cr_wr), .cr_addr_o(cr_addr), .cr_wdata_o(cr_wdata),
    .cr_ack_i(cr_ack), .cr_rdata_i(cr_rdata), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic end_test();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ---------------- control-port model ----------------
  logic [15:0] mem [logic [15:0]];
  bit          fresh = 1;
  bit          ack_en = 1;
  int          lat_c = 0, rd_cnt = 0, wr_cnt = 0;
  logic [15:0] wr_addr_q[$];

  initial begin
    cr_ack = 0; cr_rdata = '0;
    forever @(negedge clk) begin
      if (cr_ack) cr_ack = 0;
      else if (cr_req && ack_en) begin
        lat_c++;
        if (lat_c == LAT) begin
          lat_c = 0;
          cr_ack = 1;
          if (cr_wr) begin
            mem[cr_addr] = cr_wdata;
            fresh = 1;
            wr_cnt++;
            wr_addr_q.push_back(cr_addr);
          end else begin
            rd_cnt++;
            if (fresh) begin cr_rdata = 16'hBAD0; fresh = 0; end
            else cr_rdata = mem.exists(cr_addr) ? mem[cr_addr] : 16'h0;
          end
        end
      end else lat_c = 0;
    end
  end

  // ---------------- per-clock monitor ----------------
  typedef struct { int t; logic [31:0] v; } ev_t;
  ev_t evq[$];
  int          cyc = 0, done_n = 0, done_t = 0;
  logic        done_err = 0;
  logic [31:0] last_ctrl = '0;
  bit          mon_on = 0;

  initial forever @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (phy_ctrl !== last_ctrl) begin
        evq.push_back('{cyc, phy_ctrl});
        last_ctrl = phy_ctrl;
      end
      if (done) begin done_n++; done_t = cyc; done_err = err; end
    end
  end

  // ---------------- reference model ----------------
  logic [31:0] exp_v[$];
  int          exp_g[$];

  function automatic logic [15:0] ref_rx(input logic [15:0] d);
    return {d[15:12], 1'b1, 3'd3, 1'b1, 1'b0, d[5:0]};
  endfunction
  function automatic logic [15:0] ref_tx(input logic [15:0] d);
    return {d[15], 1'b1, 7'd22, 7'd127};
  endfunction
  function automatic logic [31:0] ref_param(input logic [31:0] o);
    return {o[31:27], 7'd127, o[19:14], 6'd22, o[7:3], 3'd5};
  endfunction

  // collapse steps that leave the control word unchanged
  task automatic build(input logic [31:0] c0, input logic [31:0] sv[4], input int sg[4], input int n);
    logic [31:0] prev = c0;
    int pend = 0;
    exp_v.delete(); exp_g.delete();
    for (int i = 0; i < n; i++) begin
      pend += sg[i];
      if (sv[i] != prev) begin
        exp_v.push_back(sv[i]); exp_g.push_back(pend);
        pend = 0; prev = sv[i];
      end
    end
  endtask

  task automatic compare_events(input string tag);
    chk({tag, " event count"}, evq.size(), exp_v.size());
    for (int i = 0; i < exp_v.size() && i < evq.size(); i++) begin
      chk({tag, " value"}, evq[i].v, exp_v[i]);
      if (i > 0) chk({tag, " gap"}, evq[i].t - evq[i-1].t, exp_g[i]);
    end
  endtask

  task automatic expect_bringup(input logic [31:0] c0, input bit ext);
    logic [31:0] v3 = ext ? (c0 | 32'h1000_0000) : (c0 & ~32'h1000_0000);
    build(c0, '{c0 | 32'h80, c0, v3, v3 | 32'h0100_0100}, '{0, N1, 1, N2}, 4);
  endtask

  task automatic expect_shutdown(input logic [31:0] c0);
    logic [31:0] a = c0 & ~32'h100;
    logic [31:0] b = a & ~32'h1000_0000;
    build(c0, '{a, b, b | 32'h0800_0000, 32'h0}, '{1, 1, 1, 0}, 3);
  endtask

  task automatic pulse(input bit s, input bit p);
    @(negedge clk); start = s; stop = p;
    @(negedge clk); start = 0; stop = 0;
  endtask

  task automatic arm();
    evq.delete(); done_n = 0; last_ctrl = phy_ctrl;
  endtask

  task automatic wait_done();
    int k = 0;
    while (done_n == 0 && k < 5000) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    end_test();
  end

  logic [31:0] c0, p0;
  int          w0, r0;

  initial begin
    rst_n = 0; start = 0; stop = 0; ext_ref = 1; rb_flip = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", phy_ctrl, 32'h0);
    chk("R1 param", param, PINIT);
    chk("R1 done", done, 1'b0);
    chk("R1 err", err, 1'b0);
    chk("R1 req", cr_req, 1'b0);
    @(negedge clk); rst_n = 1; mon_on = 1;

    // bring-up with external reference; commands mid-run must be ignored (R11)
    mem[16'h1006] = 16'h0040; mem[16'h1002] = 16'h8001;
    arm(); c0 = phy_ctrl;
    pulse(1, 0);
    repeat (100) @(negedge clk);
    pulse(0, 1); pulse(1, 0);
    wait_done();
    repeat (20) @(negedge clk);
    expect_bringup(c0, 1); compare_events("R2 R3 R11 bring-up ext");
    chk("R11 single done", done_n, 1);
    chk("R8 no error", done_err, 1'b0);
    chk("R5 rx value", mem[16'h1006], ref_rx(16'h0040));
    chk("R6 tx value", mem[16'h1002], ref_tx(16'h8001));
    chk("R4 reads", rd_cnt, 4);
    chk("R4 writes", wr_cnt, 2);
    chk("R5 first write addr", wr_addr_q[0], 16'h1006);
    chk("R6 second write addr", wr_addr_q[1], 16'h1002);
    chk("R7 param merge", param, ref_param(PINIT));

    // shutdown
    arm(); c0 = phy_ctrl;
    pulse(0, 1); wait_done();
    expect_shutdown(c0); compare_events("R10 shutdown");
    chk("R10 done with last step", done_t, evq.size() > 0 ? evq[evq.size()-1].t : -1);
    chk("R10 done count", done_n, 1);

    // bring-up without external reference, readback corrupted
    mem[16'h1006] = 16'hF0F5; mem[16'h1002] = 16'h0123;
    ext_ref = 0; rb_flip = 32'h0000_0100; p0 = param;
    arm(); c0 = phy_ctrl;
    pulse(1, 0); wait_done();
    expect_bringup(c0, 0); compare_events("R2 R3 bring-up no ext");
    chk("R8 mismatch error", done_err, 1'b1);
    chk("R7 param merge again", param, ref_param(p0));
    chk("R5 rx preserve", mem[16'h1006], ref_rx(16'hF0F5));
    chk("R6 tx preserve", mem[16'h1002], ref_tx(16'h0123));
    rb_flip = '0;

    arm(); pulse(0, 1); wait_done();
    chk("R10 retention word", phy_ctrl, 32'h0900_0000);

    // silent port: abort; start and stop together (start wins)
    ack_en = 0; ext_ref = 1; w0 = wr_cnt; r0 = rd_cnt; p0 = param;
    arm(); c0 = phy_ctrl;
    pulse(1, 1); wait_done();
    chk("R11 start priority", evq.size() > 0 ? evq[0].v : 32'hX, c0 | 32'h80);
    chk("R9 abort error", done_err, 1'b1);
    chk("R9 abort done", done_n, 1);
    chk("R9 no writes", wr_cnt, w0);
    chk("R9 no reads", rd_cnt, r0);
    chk("R9 param kept", param, p0);
    chk("R9 req released", cr_req, 1'b0);
    chk("R9 enabled word", phy_ctrl, 32'h1900_0100);
    end_test();
  end
endmodule